// File: doc/BRIEF.md
# Page-Mode Parallel ROM Read Controller

This block sits between an on-chip requester and an asynchronous parallel mask ROM that offers a fast in-page read path. A read arrives on a valid/ready handshake as an address, a flag that picks 16-bit or 8-bit organisation, and an extra-beat count. The controller drives the ROM address bus, chip enable, output enable and the byte/word select. It waits a fixed number of clock cycles, captures the data pins, and returns each beat with a one-cycle valid strobe.

The controller remembers the page it last opened. A later read in the same organisation whose address bits above the page offset match that page takes the short in-page wait. Any other read takes the full random-access wait. Chip enable stays active for a few idle cycles after a read, so back-to-back traffic can keep hitting the page. One ROM pin has two roles: it is the least significant byte-address bit when the controller drives it in 8-bit mode, and it is data bit 15 when the controller releases it in 16-bit mode.

Top module: `pgrom_rdctl`

## Requirements
- R1: While reset is held and just after it, chip enable is inactive (romCeN=1), output enable is inactive, rspValid=0, reqReady=1, romWordSel=1, and the shared pin is released (romLsbOe=0).
- R2: In 8-bit mode (reqWordMode=0), reqAddr is a 23-bit byte address. romAddr carries byte-address bits [22:1], romLsbOut carries bit 0, and romLsbOe=1. In 16-bit mode (reqWordMode=1), reqAddr[21:0] is a word address. romAddr carries that word address and romLsbOe=0.
- R3: In 16-bit mode, a beat returns rspData = {romLsbIn, romDataIn[14:0]}. In 8-bit mode, it returns {8'h00, romDataIn[7:0]}, and romDataIn[14:8] has no effect.
- R4: A read that misses the open page has its first beat captured LONG_CYC clock edges after the accepting edge. LONG_CYC is the ceiling of max(access time, output-enable time) divided by the clock period.
- R5: A read hits the open page when its mode is the same and its byte-address bits [22:PG_BITS] are equal to those of the page. A word address is taken as byte address = word address times 2. A hit has its first beat captured SHORT_CYC edges after acceptance, where SHORT_CYC is the ceiling of the page time divided by the clock period.
- R6: reqLen asks for that many extra beats. Beats step upward by one byte or one word, and each comes SHORT_CYC edges after the previous one. The burst is cut at the last offset of the page. rspLast=1 marks only the final beat.
- R7: A read whose mode differs from the open page takes the LONG_CYC wait. romWordSel does not change while an access is in progress.
- R8: Chip enable stays active for HOLD_CYC edges after the final beat is captured. A request accepted within that window can hit. After the window, chip enable goes inactive and the page is forgotten, so the next read takes the LONG_CYC wait.
- R9: OE_POL picks the output-enable level: 0 means romOe is low exactly while chip enable is active, 1 means it is high exactly then, and 2 means romOe stays at 0.
- R10: reqReady is 0 from the accepting edge until the final beat is captured, and 1 otherwise.
- R11: romAddr and romLsbOut do not change between the edge that applies a beat's address and the edge that captures that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Read request present |
| reqReady | output | 1 | Controller can accept a request |
| reqAddr | input | ROM_AW+1 | Byte address (8-bit mode) or word address in the low ROM_AW bits (16-bit mode) |
| reqWordMode | input | 1 | 1 selects 16-bit organisation, 0 selects 8-bit |
| reqLen | input | PG_BITS | Number of extra beats requested |
| rspValid | output | 1 | One-cycle strobe for a returned beat |
| rspData | output | 16 | Returned beat |
| rspLast | output | 1 | Marks the final beat of a request |
| romAddr | output | ROM_AW | ROM address bus |
| romCeN | output | 1 | ROM chip enable, active low |
| romOe | output | 1 | ROM output enable, level set by OE_POL |
| romWordSel | output | 1 | ROM organisation select, 1 means 16-bit |
| romLsbOut | output | 1 | Value for the shared pin in 8-bit mode |
| romLsbOe | output | 1 | Drive enable for the shared pin |
| romLsbIn | input | 1 | Shared pin as seen by the controller (data bit 15 in 16-bit mode) |
| romDataIn | input | 15 | ROM data pins 0 to 14 |

## Verification
The bench uses a ROM model that returns a poison word unless the upper address, mode and enables have been stable for the long wait and the page offset for the short wait. Data is therefore correct only if the controller waited long enough. Each capture is also timed exactly to the edge, which separates too-long waits from correct ones. Reads sweep every page offset in both organisations with single beats, mid-length bursts and full-page requests, and each read is repeated at once. This separates miss from hit timing, ascending order from other orders, and truncation at the page end from wrapping. Directed sequences switch organisation inside an open page, and place a request just inside and just outside the chip-enable hold window, which tells a kept page from a forgotten one.

// File: rtl/pgrom_pkg.sv
package pgrom_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HOLD = 2'd2
  } pgState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic nextBeat;
    logic capture;
    logic closePage;
  } pgStrobe_t;

endpackage

// File: rtl/pgrom_dpath.sv
module pgrom_dpath
  import pgrom_pkg::*;
#(
  parameter int ROM_AW  = 22,
  parameter int PG_BITS = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  pgStrobe_t           stb,
  input  logic [ROM_AW:0]     reqAddr,
  input  logic                reqWordMode,
  input  logic [PG_BITS-1:0]  reqLen,
  output logic                reqHit,
  output logic                lastBeat,
  output logic [ROM_AW-1:0]   romAddr,
  output logic                romLsbOut,
  output logic                romLsbOe,
  output logic                romWordSel,
  input  logic [14:0]         romDataIn,
  input  logic                romLsbIn,
  output logic                rspValid,
  output logic [15:0]         rspData,
  output logic                rspLast
);

  localparam int BA_W = ROM_AW + 1;
  localparam int UP_W = BA_W - PG_BITS;
  localparam logic [PG_BITS-1:0] OFF_MAX_B = '1;
  localparam logic [PG_BITS-1:0] OFF_MAX_W = OFF_MAX_B >> 1;

  logic [BA_W-1:0]    reqByte;
  logic [BA_W-1:0]    curByte;
  logic               curWord;
  logic [PG_BITS-1:0] beatsLeft;
  logic [PG_BITS-1:0] offB, offW, room, firstLeft;
  logic               pageValid;
  logic [UP_W-1:0]    pageUp;
  logic               pageWord;
  logic [BA_W-1:0]    stepVal;

  // word addresses live in the byte-address space, bit 0 cleared
  assign reqByte   = reqWordMode ? {reqAddr[ROM_AW-1:0], 1'b0} : reqAddr;
  assign offB      = reqByte[PG_BITS-1:0];
  assign offW      = {1'b0, reqByte[PG_BITS-1:1]};
  assign room      = reqWordMode ? (OFF_MAX_W - offW) : (OFF_MAX_B - offB);
  assign firstLeft = (reqLen > room) ? room : reqLen;

  assign reqHit = pageValid && (pageWord == reqWordMode) &&
                  (pageUp == reqByte[BA_W-1:PG_BITS]);
  assign lastBeat = (beatsLeft == '0);
  assign stepVal  = curWord ? BA_W'(2) : BA_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curByte   <= '0;
      curWord   <= 1'b1;
      beatsLeft <= '0;
      pageValid <= 1'b0;
      pageUp    <= '0;
      pageWord  <= 1'b1;
    end else begin
      if (stb.loadReq) begin
        curByte   <= reqByte;
        curWord   <= reqWordMode;
        beatsLeft <= firstLeft;
        pageValid <= 1'b1;
        pageUp    <= reqByte[BA_W-1:PG_BITS];
        pageWord  <= reqWordMode;
      end else if (stb.nextBeat) begin
        curByte   <= curByte + stepVal;
        beatsLeft <= beatsLeft - 1'b1;
      end
      if (stb.closePage) pageValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
      rspLast  <= 1'b0;
    end else begin
      rspValid <= stb.capture;
      if (stb.capture) begin
        rspData <= curWord ? {romLsbIn, romDataIn} : {8'h00, romDataIn[7:0]};
        rspLast <= lastBeat;
      end
    end
  end

  assign romAddr    = curByte[BA_W-1:1];
  assign romLsbOut  = curByte[0];
  assign romLsbOe   = !curWord;
  assign romWordSel = curWord;

endmodule

// File: rtl/pgrom_ctrl.sv
module pgrom_ctrl
  import pgrom_pkg::*;
#(
  parameter int LONG_CYC  = 5,
  parameter int SHORT_CYC = 2,
  parameter int HOLD_CYC  = 4,
  parameter int OE_POL    = 0
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  output logic      reqReady,
  input  logic      reqHit,
  input  logic      lastBeat,
  output pgStrobe_t stb,
  output logic      romCeN,
  output logic      romOe
);

  localparam int M1      = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CNT_MAX = (M1 > HOLD_CYC) ? M1 : HOLD_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_CYC - 1);
  localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);

  pgState_t         state;
  logic [CNT_W-1:0] cnt;
  logic             fire;
  logic             ceOn;

  assign reqReady = (state != ST_WAIT);
  assign fire     = reqValid && reqReady;
  assign ceOn     = (state != ST_IDLE);

  always_comb begin
    stb = '0;
    case (state)
      ST_IDLE, ST_HOLD: begin
        if (fire) stb.loadReq = 1'b1;
        else if (state == ST_HOLD && cnt == '0) stb.closePage = 1'b1;
      end
      ST_WAIT: begin
        if (cnt == '0) begin
          stb.capture  = 1'b1;
          stb.nextBeat = !lastBeat;
        end
      end
      default: ;
    endcase
  end

  // one counter serves the access wait and the enable hold window
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_HOLD: begin
          if (fire) begin
            cnt   <= reqHit ? SHORT_LD : LONG_LD;
            state <= ST_WAIT;
          end else if (state == ST_HOLD) begin
            if (cnt == '0) state <= ST_IDLE;
            else           cnt   <= cnt - 1'b1;
          end
        end
        ST_WAIT: begin
          if (cnt == '0) begin
            if (lastBeat) begin
              state <= ST_HOLD;
              cnt   <= HOLD_LD;
            end else begin
              cnt <= SHORT_LD;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign romCeN = !ceOn;

  generate
    if (OE_POL == 0) begin : gOeLow
      assign romOe = !ceOn;
    end else if (OE_POL == 1) begin : gOeHigh
      assign romOe = ceOn;
    end else begin : gOeNone
      assign romOe = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/pgrom_rdctl.sv
module pgrom_rdctl
  import pgrom_pkg::*;
#(
  parameter int CLK_PS   = 20000,
  parameter int ACC_PS   = 100000,
  parameter int PAGE_PS  = 25000,
  parameter int OE_PS    = 25000,
  parameter int HOLD_CYC = 4,
  parameter int PG_BITS  = 3,
  parameter int OE_POL   = 0,
  parameter int ROM_AW   = 22
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [ROM_AW:0]    reqAddr,
  input  logic               reqWordMode,
  input  logic [PG_BITS-1:0] reqLen,
  output logic               rspValid,
  output logic [15:0]        rspData,
  output logic               rspLast,
  output logic [ROM_AW-1:0]  romAddr,
  output logic               romCeN,
  output logic               romOe,
  output logic               romWordSel,
  output logic               romLsbOut,
  output logic               romLsbOe,
  input  logic               romLsbIn,
  input  logic [14:0]        romDataIn
);

  localparam int ACC_CYC   = (ACC_PS + CLK_PS - 1) / CLK_PS;
  localparam int OE_CYC    = (OE_PS + CLK_PS - 1) / CLK_PS;
  localparam int LONG_CYC  = (ACC_CYC > OE_CYC) ? ACC_CYC : OE_CYC;
  localparam int PG_CYC    = (PAGE_PS + CLK_PS - 1) / CLK_PS;
  localparam int SHORT_CYC = (PG_CYC < 1) ? 1 : PG_CYC;

  pgStrobe_t stb;
  logic      reqHit;
  logic      lastBeat;

  pgrom_ctrl #(
    .LONG_CYC (LONG_CYC),
    .SHORT_CYC(SHORT_CYC),
    .HOLD_CYC (HOLD_CYC),
    .OE_POL   (OE_POL)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .reqHit  (reqHit),
    .lastBeat(lastBeat),
    .stb     (stb),
    .romCeN  (romCeN),
    .romOe   (romOe)
  );

  pgrom_dpath #(
    .ROM_AW (ROM_AW),
    .PG_BITS(PG_BITS)
  ) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .reqAddr    (reqAddr),
    .reqWordMode(reqWordMode),
    .reqLen     (reqLen),
    .reqHit     (reqHit),
    .lastBeat   (lastBeat),
    .romAddr    (romAddr),
    .romLsbOut  (romLsbOut),
    .romLsbOe   (romLsbOe),
    .romWordSel (romWordSel),
    .romDataIn  (romDataIn),
    .romLsbIn   (romLsbIn),
    .rspValid   (rspValid),
    .rspData    (rspData),
    .rspLast    (rspLast)
  );

endmodule

// File: rtl/pgrom_rdctl_chk.sv
module pgrom_rdctl_chk #(
  parameter int ROM_AW = 22,
  parameter int OE_POL = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic [ROM_AW-1:0] romAddr,
  input logic              romLsbOut,
  input logic              romCeN,
  input logic              romOe,
  input logic              romWordSel,
  input logic              romLsbOe
);

  logic expOe;
  assign expOe = (OE_POL == 0) ? romCeN : ((OE_POL == 1) ? !romCeN : 1'b0);

  AST_PIN_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    romWordSel |-> !romLsbOe); // R2

  AST_OE_FOLLOWS_CE: assert property (@(posedge clk) disable iff (!rstN)
    romOe == expOe); // R9

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!reqReady && $past(!reqReady) && !rspValid) |-> ($stable(romAddr) && $stable(romLsbOut))); // R11

  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!reqReady && $past(!reqReady)) |-> $stable(romWordSel)); // R7

  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rstN)
    romCeN |-> reqReady); // R10

  AST_BEAT_UNDER_CE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !romCeN); // R8

endmodule

bind pgrom_rdctl pgrom_rdctl_chk #(
  .ROM_AW(ROM_AW),
  .OE_POL(OE_POL)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .reqReady  (reqReady),
  .rspValid  (rspValid),
  .romAddr   (romAddr),
  .romLsbOut (romLsbOut),
  .romCeN    (romCeN),
  .romOe     (romOe),
  .romWordSel(romWordSel),
  .romLsbOe  (romLsbOe)
);

// File: tb/pgrom_rdctl_tb_top.sv
module pgrom_rdctl_tb_top;

  localparam int HOLD  = 4;
  localparam int PB    = 3;
  localparam int LONG  = (100 + 19) / 20;
  localparam int SHORT = (25 + 19) / 20;
  localparam int WD    = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [22:0] reqAddr = '0;
  logic        reqWordMode = 1'b0;
  logic [2:0]  reqLen = '0;
  logic        rspValid;
  logic [15:0] rspData;
  logic        rspLast;
  logic [21:0] romAddr;
  logic        romCeN, romOe, romWordSel, romLsbOut, romLsbOe, romLsbIn;
  logic [14:0] romDataIn = '0;
  logic        pinBit = 1'b0;

  int nChk = 0;
  int nBad = 0;
  int cyc  = 0;

  pgrom_rdctl dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWordMode(reqWordMode), .reqLen(reqLen),
    .rspValid(rspValid), .rspData(rspData), .rspLast(rspLast),
    .romAddr(romAddr), .romCeN(romCeN), .romOe(romOe), .romWordSel(romWordSel),
    .romLsbOut(romLsbOut), .romLsbOe(romLsbOe), .romLsbIn(romLsbIn),
    .romDataIn(romDataIn)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (cyc == WD) begin
      nBad = nBad + 1;
      $display("FAIL watchdog R10 actual=%0d expected<%0d", cyc, WD);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk + 1, nBad);
      $finish;
    end
  end

  function automatic logic [15:0] wordData(input logic [21:0] w);
    return w[15:0] ^ {w[21:16], w[9:0]} ^ 16'h3C96;
  endfunction

  function automatic logic [7:0] byteData(input logic [22:0] b);
    logic [15:0] d;
    d = wordData(b[22:1]);
    return b[0] ? d[15:8] : d[7:0];
  endfunction

  // ROM model: correct data only after the long and short settle times
  logic [21:0] prevUp = '0;
  logic [23:0] prevShort = '0;
  int longAge = 0;
  int shortAge = 0;
  assign romLsbIn = romLsbOe ? romLsbOut : pinBit;

  always @(negedge clk) begin
    logic [21:0] upKey;
    logic [23:0] shKey;
    logic [15:0] d;
    upKey = {romWordSel, romCeN, romAddr[21:2]};
    shKey = {romAddr, romLsbOut, romLsbOe};
    if (upKey != prevUp) longAge = 0; else if (longAge < 1000) longAge = longAge + 1;
    if (shKey != prevShort) shortAge = 0; else if (shortAge < 1000) shortAge = shortAge + 1;
    prevUp = upKey;
    prevShort = shKey;
    if (!romCeN && !romOe && longAge >= LONG - 1 && shortAge >= SHORT - 1) begin
      if (romWordSel) begin
        d = wordData(romAddr);
        romDataIn = d[14:0];
        pinBit = d[15];
      end else begin
        romDataIn = {7'h55, byteData({romAddr, romLsbOut})};
        pinBit = 1'b1;
      end
    end else begin
      romDataIn = 15'h5EAD;
      pinBit = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChk = nChk + 1;
    if (!ok) begin
      nBad = nBad + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // page tracker of the bench
  bit          pgOpen = 0;
  logic [19:0] pgUp = '0;
  bit          pgWord = 0;
  int          lastBeatCyc = 0;

  task automatic doRead(input logic [22:0] a, input bit wm, input int len, input string tag);
    logic [22:0] b0, bk;
    int off, pmax, nb, n, expN;
    bit hit;
    logic [15:0] expD;
    b0   = wm ? {a[21:0], 1'b0} : a;
    off  = wm ? int'(b0[2:1]) : int'(b0[2:0]);
    pmax = wm ? 3 : 7;
    nb   = ((len > pmax - off) ? (pmax - off) : len) + 1;
    @(negedge clk);
    reqAddr = a; reqWordMode = wm; reqLen = 3'(len); reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    hit = pgOpen && ((cyc + 1 - lastBeatCyc) <= HOLD) && (pgWord == wm) && (pgUp == b0[22:3]);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    // R2 address mapping and R9 enable level right after acceptance
    if (wm) begin
      chk(romAddr == a[21:0], "R2 word address", romAddr, a[21:0]);
      chk(romLsbOe == 1'b0, "R2 pin released", romLsbOe, 0);
    end else begin
      chk({romAddr, romLsbOut} == a, "R2 byte address", {romAddr, romLsbOut}, a);
      chk(romLsbOe == 1'b1, "R2 pin driven", romLsbOe, 1);
    end
    chk(romOe == romCeN && !romCeN, "R9 oe level", romOe, 0);
    n = 0;
    expN = hit ? SHORT : LONG;
    for (int k = 0; k < nb; k++) begin
      do begin
        @(posedge clk);
        n = n + 1;
        @(negedge clk);
        if (!rspValid && k == 0 && n == 1)
          chk(reqReady == 1'b0, "R10 busy", reqReady, 0);
      end while (!rspValid && n < 200);
      if (k == 0)
        chk(n == expN, {tag, hit ? " R5 hit wait" : " R4 miss wait"}, n, expN);
      else
        chk(n == expN, "R6 beat spacing", n, expN);
      bk = wm ? (b0 + 23'(2 * k)) : (b0 + 23'(k));
      expD = wm ? wordData(bk[22:1]) : {8'h00, byteData(bk)};
      chk(rspData == expD, wm ? "R3 R11 word data" : "R3 R11 byte data", rspData, expD);
      chk(rspLast == (k == nb - 1), "R6 last flag", rspLast, (k == nb - 1));
      expN = expN + SHORT;
    end
    chk(reqReady == 1'b1, "R10 ready after burst", reqReady, 1);
    pgOpen = 1;
    pgUp = b0[22:3];
    pgWord = wm;
    lastBeatCyc = cyc;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(romCeN == 1'b1 && romOe == 1'b1, "R1 enables in reset", {romCeN, romOe}, 3);
    chk(rspValid == 1'b0 && reqReady == 1'b1, "R1 handshake in reset", {rspValid, reqReady}, 1);
    chk(romLsbOe == 1'b0 && romWordSel == 1'b1, "R1 pin in reset", {romLsbOe, romWordSel}, 1);
    rstN = 1'b1;
    @(negedge clk);
    chk(romCeN == 1'b1 && reqReady == 1'b1 && rspValid == 1'b0, "R1 after reset",
        {romCeN, reqReady, rspValid}, 6);

    // directed: miss, hit, mode change, bursts
    doRead(23'h012345, 1'b1, 0, "R4 first");
    doRead(23'h012346, 1'b1, 0, "R5 same page");
    doRead(23'h02468C, 1'b0, 0, "R7 mode change");
    doRead(23'h02468D, 1'b0, 0, "R5 byte hit");
    doRead(23'h02468A, 1'b1, 0, "R7 back to word");
    doRead(23'h1F0008, 1'b0, 7, "R6 full byte burst");
    doRead(23'h1F000D, 1'b0, 7, "R6 cut byte burst");
    doRead(23'h0A0001, 1'b1, 3, "R6 cut word burst");

    // R8 hold window: still open just inside, closed after
    idle(HOLD - 1);
    chk(romCeN == 1'b0, "R8 ce held", romCeN, 0);
    idle(1);
    chk(romCeN == 1'b1, "R8 ce released", romCeN, 1);
    doRead(23'h0A0002, 1'b1, 0, "R8 after release");
    idle(HOLD - 2);
    doRead(23'h0A0003, 1'b1, 0, "R8 last edge of window");
    idle(HOLD - 1);
    doRead(23'h0A0000, 1'b1, 0, "R8 one past window");

    // sweep every offset in both modes, with repeats
    for (int wm = 0; wm < 2; wm++) begin
      for (int off = 0; off < (wm ? 4 : 8); off++) begin
        for (int li = 0; li < 3; li++) begin
          int len;
          logic [19:0] up;
          logic [22:0] a;
          len = (li == 0) ? 0 : ((li == 1) ? 2 : 7);
          up = 20'h30000 + 20'(off * 7 + li * 131 + wm * 977);
          a = wm ? {1'b0, up, 2'(off)} : {up, 3'(off)};
          doRead(a, bit'(wm), len, "sweep");
          doRead(a, bit'(wm), len, "sweep repeat");
        end
      end
    end

    idle(HOLD + 2);
    chk(romCeN == 1'b1 && rspValid == 1'b0, "R8 quiet at end", {romCeN, rspValid}, 2);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule